// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This block sits beside one processor and decides which pending interrupt, if any, that processor should see. A fixed set of external sources each raise a one-cycle request that is latched as pending, together with an 8-bit priority supplied alongside it. One extra source, the inter-processor interrupt, is requested through its own priority byte. The unit compares the most favoured pending request against the processor's current priority and drives a single interrupt line to the core.

Software talks to the unit through a small 32-bit register window with byte strobes. One word packs the current priority (top byte) with a 24-bit source number (low bits). Reading it through the acknowledging address hands out the winning source and raises the processor priority to that source's level. Writing the same word format back ends service of the named source and restores the priority. A poll address returns the same word without side effects. Numerically smaller priority values are more favoured, and 0xFF is the most permissive processor priority.

Top module: `ipc_present`

## Requirements
- R1: After synchronous active-high reset the processor priority is 0x00, the IPI priority byte is 0xFF, nothing is pending or in service, `cpu_irq` is low, and a poll read returns 0x00000000.
- R2: A write to byte address 0 or 4 with `bus_wstrb[3]` set loads `bus_wdata[31:24]` into the processor priority. When the strobe is not 4'b1111, no other state changes.
- R3: `cpu_irq` is high exactly when an eligible request has a priority strictly below the processor priority. With priority 0x00 every request is rejected.
- R4: Among eligible requests, the lowest priority value wins, and ties go to the lower source number. The IPI is source 2, and external source i is source SRC_BASE+i (default 16+i).
- R5: A read of address 0 returns {processor priority, 24-bit presented source}, where the source field is 0 when `cpu_irq` is low. The read changes no state.
- R6: A read of address 4 while a request is presented returns {old processor priority, winning source}. It then sets the processor priority to the winner's priority. For an external winner, it also clears that source's pending bit and marks the source in service.
- R7: A read of address 4 with nothing presented returns {processor priority, 0} and changes no state.
- R8: A write to address 4 with strobe 4'b1111 loads the top byte as the processor priority and ends service of the source named in bits 23:0. An in-service external source is not eligible, but a new request for it is held pending until that end of service.
- R9: Writing byte 3 (bits 31:24) of address 12 sets the IPI priority byte. Any value other than 0xFF makes the IPI eligible at that priority, and 0xFF withdraws it. A read of address 12 returns {IPI priority, 24'h0}.
- R10: An IPI at priority 4 is presented while an external source acknowledged at priority 5 is still in service.
- R11: Read data is registered and appears one clock after the read strobe, holding until the next read. Address 8 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address within the window (bits 3:2 select the word) |
| bus_wr | input | 1 | Write strobe |
| bus_wstrb | input | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_req | input | NSRC | One-cycle request pulse per external source |
| src_prio | input | 8*NSRC | Priority of source i in bits 8i+7:8i |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
A corrupt processor priority shows up at once in two places: in the top byte of every poll and acknowledge word, and as a wrong level on `cpu_irq` in the cycle after the write or acknowledge that set it. A lost or stuck pending or in-service bit appears as a wrong or missing source number on the next acknowledge. It can also show as an interrupt that fails to return after its end of service. Errors in the arbitration order surface as the wrong source number in the acknowledge word, which is why the stimulus pits equal and unequal priorities against each other, including the IPI.

// File: rtl/ipc_present.sv
module ipc_present #(
  parameter int NSRC     = 4,
  parameter int SRC_BASE = 16,
  parameter int IPI_SRC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_wstrb,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_req,
  input  logic [8*NSRC-1:0] src_prio,
  output logic              cpu_irq
);
  localparam int NCAND = NSRC + 1;
  localparam int IW    = $clog2(NCAND + 1);

  logic [7:0]      cppr, mfrr;
  logic [NSRC-1:0] pend, insvc, ack_mask, eoi_mask;
  logic            win_v;
  logic [7:0]      win_p;
  logic [IW-1:0]   win_i;
  logic [23:0]     win_src;

  wire [1:0] word    = bus_addr[3:2];
  wire       wr_ctl  = bus_wr && (word == 2'd0 || word == 2'd1);
  wire       wr_eoi  = bus_wr && word == 2'd1 && bus_wstrb == 4'b1111;
  wire       wr_ipi  = bus_wr && word == 2'd3 && bus_wstrb[3];
  wire       rd_ack  = bus_rd && word == 2'd1;
  wire       ipi_v   = mfrr != 8'hFF;

  always_comb begin
    win_v = ipi_v;
    win_p = mfrr;
    win_i = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && !insvc[i] && (!win_v || src_prio[8*i +: 8] < win_p)) begin
        win_v = 1'b1;
        win_p = src_prio[8*i +: 8];
        win_i = IW'(i + 1);
      end
    end
  end

  assign win_src = (win_i == '0) ? 24'(IPI_SRC) : 24'(SRC_BASE) + 24'(win_i) - 24'd1;
  assign cpu_irq = win_v && (win_p < cppr);

  wire [31:0] ctl_word = {cppr, cpu_irq ? win_src : 24'd0};

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      ack_mask[i] = rd_ack && cpu_irq && win_i == IW'(i + 1);
      eoi_mask[i] = wr_eoi && bus_wdata[23:0] == 24'(SRC_BASE + i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr      <= 8'h00;
      mfrr      <= 8'hFF;
      pend      <= '0;
      insvc     <= '0;
      bus_rdata <= '0;
    end else begin
      pend  <= (pend & ~ack_mask) | src_req;
      insvc <= (insvc & ~eoi_mask) | ack_mask;
      if (wr_ctl && bus_wstrb[3])
        cppr <= bus_wdata[31:24];
      else if (rd_ack && cpu_irq)
        cppr <= win_p;
      if (wr_ipi)
        mfrr <= bus_wdata[31:24];
      if (bus_rd) begin
        case (word)
          2'd0, 2'd1: bus_rdata <= ctl_word;
          2'd3:       bus_rdata <= {mfrr, 24'd0};
          default:    bus_rdata <= 32'd0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipc_present_chk.sv
module ipc_present_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [31:0]     bus_rdata,
  input logic [NSRC-1:0] src_req,
  input logic            cpu_irq,
  input logic [7:0]      cppr,
  input logic [7:0]      win_p,
  input logic [NSRC-1:0] pend
);
  assert_zero_masks_R3: assert property (@(posedge clk) disable iff (rst)
    (cppr == 8'h00) |-> !cpu_irq);

  assert_strict_compare_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (win_p < cppr));

  assert_ack_raises_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:2] == 2'd1 && cpu_irq && !bus_wr) |=> (cppr == $past(win_p)));

  assert_poll_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:2] == 2'd0 && !bus_wr && src_req == '0) |=> ($stable(cppr) && $stable(pend)));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind ipc_present ipc_present_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .src_req(src_req), .cpu_irq(cpu_irq),
  .cppr(cppr), .win_p(win_p), .pend(pend)
);

// File: tb/ipc_present_tb_top.sv
module ipc_present_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [3:0]        bus_wstrb = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_rdata;
  logic [NSRC-1:0]   src_req = '0;
  logic [8*NSRC-1:0] src_prio = '0;
  logic              cpu_irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  ipc_present #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .src_req(src_req), .src_prio(src_prio),
    .cpu_irq(cpu_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {prios[79:48], req[47:40], ipi prio[39:32], cpu prio[31:24], src[23:16], winner prio[15:8], irq[7:0]}
  localparam logic [79:0] VEC [0:9] = '{
    80'h05050505_01_FF_FF_10_05_01,
    80'h03070305_0F_FF_FF_11_03_01,
    80'h03070305_08_FF_FF_13_03_01,
    80'h05050505_01_04_FF_02_04_01,
    80'h05050505_01_05_FF_02_05_01,
    80'h05050505_01_FF_05_00_00_00,
    80'h05050505_01_FF_06_10_05_01,
    80'h00000000_0F_00_00_00_00_00,
    80'h06070809_0F_FF_FF_13_06_01,
    80'h05050505_00_FF_FF_00_00_00
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wstrb = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] r);
    @(negedge clk); src_req = r;
    @(negedge clk); src_req = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] d2;
    do_reset();

    // R1 reset state
    check("R1 irq", {31'd0, cpu_irq}, 32'd0);
    rd(4'd0, d);  check("R1 poll", d, 32'h00000000);
    rd(4'd12, d); check("R1 ipi byte", d, 32'hFF000000);

    // R3: priority 0 rejects a pending request
    src_prio = 32'h01010101;
    pulse(4'b0001);
    check("R3 zero masks", {31'd0, cpu_irq}, 32'd0);

    // Vector table: R3 R4 R6
    for (int v = 0; v < 10; v++) begin
      logic [79:0] e;
      e = VEC[v];
      do_reset();
      src_prio = e[79:48];
      wr(4'd12, 4'b1000, {e[39:32], 24'h123456});
      wr(4'd4, 4'b1000, {e[31:24], 24'hABCDEF});
      pulse(e[43:40]);
      check($sformatf("R3 vec%0d irq", v), {31'd0, cpu_irq}, {31'd0, e[0]});
      rd(4'd4, d);
      check($sformatf("R4 vec%0d ack", v), d, {e[31:24], 16'd0, e[23:16]});
      rd(4'd0, d);
      check($sformatf("R6 vec%0d prio", v), {24'd0, d[31:24]},
            {24'd0, e[0] ? e[15:8] : e[31:24]});
    end

    // R2: priority-only byte write leaves the source side alone
    do_reset();
    wr(4'd4, 4'b1000, 32'hFF000010);
    rd(4'd0, d); check("R2 byte write", d, 32'hFF000000);
    wr(4'd0, 4'b1000, 32'h07FFFFFF);
    rd(4'd0, d); check("R2 byte write offset0", d, 32'h07000000);

    // R5 poll has no side effect; R7 empty ack
    do_reset();
    wr(4'd4, 4'b1000, 32'hFF000000);
    rd(4'd4, d); check("R7 empty ack", d, 32'hFF000000);
    rd(4'd0, d); check("R7 prio kept", d, 32'hFF000000);
    src_prio = 32'h05050505;
    pulse(4'b0010);
    rd(4'd0, d); rd(4'd0, d2);
    check("R5 poll word", d, 32'hFF000011);
    check("R5 poll repeat", d2, 32'hFF000011);
    rd(4'd4, d); check("R5 ack after poll", d, 32'hFF000011);

    // R8 in-service source held until EOI; R10 IPI preempts
    do_reset();
    wr(4'd4, 4'b1000, 32'hFF000000);
    src_prio = 32'h05050505;
    pulse(4'b0001);
    rd(4'd4, d); check("R6 ack src0", d, 32'hFF000010);
    wr(4'd12, 4'b1000, 32'h04000000);
    check("R10 ipi irq", {31'd0, cpu_irq}, 32'd1);
    rd(4'd0, d); check("R10 ipi poll", d, 32'h05000002);
    rd(4'd4, d); check("R10 ipi ack", d, 32'h05000002);
    rd(4'd12, d); check("R9 ipi readback", d, 32'h04000000);
    wr(4'd12, 4'b1000, 32'hFF000000);
    wr(4'd4, 4'b1111, 32'h05000002);
    check("R9 ipi withdrawn", {31'd0, cpu_irq}, 32'd0);
    pulse(4'b0001);
    wr(4'd4, 4'b1000, 32'hFF000000);
    check("R8 held while in service", {31'd0, cpu_irq}, 32'd0);
    rd(4'd0, d); check("R8 held poll", d, 32'hFF000000);
    wr(4'd4, 4'b1111, 32'hFF000010);
    check("R8 after eoi irq", {31'd0, cpu_irq}, 32'd1);
    rd(4'd0, d); check("R8 after eoi poll", d, 32'hFF000010);

    // R11 unused word; read data holds
    wr(4'd8, 4'b1111, 32'hDEADBEEF);
    rd(4'd8, d); check("R11 unused word", d, 32'h00000000);
    repeat (3) @(negedge clk);
    check("R11 rdata holds", bus_rdata, 32'h00000000);
    rd(4'd0, d); check("R11 state after unused write", d, 32'hFF000010);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule